// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns the reference PWM waveform of one channel into a pair of pin drives: a main output and a complementary output. Each drive has a level and an output-enable, so a pin can also be released. When both outputs are enabled and the gate enable is on, the block inserts a programmable dead-time at every turn-on edge. The main output goes active only once the reference has stayed high for the dead-time. The complementary output goes active only once the reference has stayed low for the dead-time. Turn-off edges are never delayed. A pulse shorter than the dead-time therefore never reaches its pin.

An 8-bit code sets the dead-time in four ranges, each with its own step. The unit is a base tick given as a clock-enable input. Each output has its own polarity. A run-mode off-state bit and an idle-mode off-state bit choose whether a disabled pin is released or kept driven. Per-pin idle levels apply whenever the gate enable is off. A trip input removes the gate enable at once, with no clock edge needed.

A single down-counter does the timing. It is reloaded at every change of the registered reference. The new reference level reaches the dead-time stage only when the counter runs out, and the counter advances only on tick cycles.

Top module: `cpl_deadtime`

## Requirements
- R1: The dead-time N in ticks comes from the code c as follows.
  - With c[7]=0, N = c.
  - With c[7:6]=10, N = 2*(64+c[5:0]).
  - With c[7:5]=110, N = 8*(32+c[4:0]).
  - With c[7:5]=111, N = 16*(32+c[4:0]).
  - With a tick on every cycle, and both outputs enabled, the main output becomes active N+1 clock edges after the reference is first sampled high.
- R2: With both outputs enabled and the gate on, the main output is active only when the reference was sampled high at the previous edge and has been stable for N ticks. Its falling edge follows the reference one cycle later.
- R3: With both outputs enabled and the gate on, the complementary output is active only when the reference was sampled low at the previous edge and has been stable for N ticks. The two outputs are never active together.
- R4: A reference pulse shorter than N ticks produces no active pulse on the output it would turn on.
- R5: For each output, polarity bit 0 makes a high level active and polarity bit 1 makes a low level active. An inactive output drives the value of its polarity bit.
- R6: With only the main output enabled and the gate on, the main output follows the reference with one cycle of latency and no dead-time. Its output-enable is 1.
- R7: With only the complementary output enabled and the gate on, the complementary output is active when the reference was high, not inverted and with no dead-time.
- R8: With the gate on, a disabled output is kept driven at its inactive level (output-enable 1) when the run-mode off-state bit is 1 and at least one output is enabled. Otherwise it is released (output-enable 0).
- R9: With the gate off, both pins drive their idle levels. Their output-enables are 1 when the idle-mode off-state bit is 1 and at least one output is enabled, and 0 otherwise.
- R10: A high trip input gives the gate-off behaviour of R9 in the same cycle, without waiting for a clock edge.
- R11: After reset the reference is taken as settled low. With both outputs enabled, active-high polarity and the gate on, the complementary output is active and the main output is inactive.
- R12: The dead-time counter advances only on clock edges where the tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference PWM waveform |
| tick_i | input | 1 | Dead-time base tick enable |
| dt_code_i | input | 8 | Dead-time code |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main polarity, 1 = active low |
| comp_pol_i | input | 1 | Complementary polarity, 1 = active low |
| gate_en_i | input | 1 | Gate (main output) enable |
| trip_i | input | 1 | Trip, clears the gate enable asynchronously |
| run_hold_i | input | 1 | Run-mode off-state: keep disabled pins driven |
| idle_hold_i | input | 1 | Idle-mode off-state: keep pins driven at idle level |
| main_idle_i | input | 1 | Main pin idle level |
| comp_idle_i | input | 1 | Complementary pin idle level |
| main_o | output | 1 | Main pin level |
| main_oe_o | output | 1 | Main pin output-enable |
| comp_o | output | 1 | Complementary pin level |
| comp_oe_o | output | 1 | Complementary pin output-enable |

## Verification
A wrong count or a wrong settled reference shows as a turn-on edge that comes one or more cycles early or late. It can also show as a short pulse that leaks through, or as both outputs active together. Any of these is visible at the pins on the first edge after the fault. A wrong range decode shifts the turn-on edge by a whole step, and the per-cycle comparison catches it as soon as the dead-time for that code expires. The enable, polarity and off-state selection are purely combinational, so a fault there shows in the same cycle that its input pattern appears.

// File: rtl/cpl_deadtime.sv
module cpl_deadtime (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_i,
  input  logic       tick_i,
  input  logic [7:0] dt_code_i,
  input  logic       main_en_i,
  input  logic       comp_en_i,
  input  logic       main_pol_i,
  input  logic       comp_pol_i,
  input  logic       gate_en_i,
  input  logic       trip_i,
  input  logic       run_hold_i,
  input  logic       idle_hold_i,
  input  logic       main_idle_i,
  input  logic       comp_idle_i,
  output logic       main_o,
  output logic       main_oe_o,
  output logic       comp_o,
  output logic       comp_oe_o
);
  localparam int CNT_W = 10;

  logic [CNT_W-1:0] span, cnt;
  logic ref_q, settled;
  logic live, any_en, main_act, comp_act;

  always_comb begin
    casez (dt_code_i)
      8'b0???????: span = {3'b000, dt_code_i[6:0]};
      8'b10??????: span = {3'b000, 1'b1, dt_code_i[5:0]} << 1;
      8'b110?????: span = {4'b0000, 1'b1, dt_code_i[4:0]} << 3;
      default:     span = {4'b0000, 1'b1, dt_code_i[4:0]} << 4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      settled <= 1'b0;
      cnt     <= '0;
    end else if (ref_i != ref_q) begin
      ref_q <= ref_i;
      cnt   <= span;
      if (span == '0) settled <= ref_i;
    end else if (tick_i && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) settled <= ref_q;
    end
  end

  assign live     = gate_en_i & ~trip_i;
  assign any_en   = main_en_i | comp_en_i;
  assign main_act = main_en_i & ref_q & (settled | ~comp_en_i);
  assign comp_act = comp_en_i & (main_en_i ? (~ref_q & ~settled) : ref_q);

  assign main_o    = live ? (main_act ^ main_pol_i) : main_idle_i;
  assign comp_o    = live ? (comp_act ^ comp_pol_i) : comp_idle_i;
  assign main_oe_o = live ? (main_en_i | (run_hold_i & any_en)) : (idle_hold_i & any_en);
  assign comp_oe_o = live ? (comp_en_i | (run_hold_i & any_en)) : (idle_hold_i & any_en);
endmodule

module cpl_deadtime_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_i,
  input logic trip_i,
  input logic gate_en_i,
  input logic main_en_i,
  input logic comp_en_i,
  input logic main_pol_i,
  input logic comp_pol_i,
  input logic run_hold_i,
  input logic idle_hold_i,
  input logic main_o,
  input logic main_oe_o,
  input logic comp_o,
  input logic comp_oe_o
);
  logic ready, live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ready <= 1'b0;
    else ready <= 1'b1;
  assign live = gate_en_i & ~trip_i;

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && main_en_i && comp_en_i) |-> !((main_o ^ main_pol_i) && (comp_o ^ comp_pol_i)));
  // R2
  main_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && live && main_en_i && (main_o ^ main_pol_i)) |-> $past(ref_i));
  // R7
  comp_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && live && comp_en_i && !main_en_i) |-> ((comp_o ^ comp_pol_i) == $past(ref_i)));
  // R8
  run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && main_en_i && !comp_en_i && !run_hold_i) |-> !comp_oe_o);
  // R10
  trip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && !idle_hold_i) |-> (!main_oe_o && !comp_oe_o));
endmodule

bind cpl_deadtime cpl_deadtime_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .trip_i(trip_i), .gate_en_i(gate_en_i),
  .main_en_i(main_en_i), .comp_en_i(comp_en_i), .main_pol_i(main_pol_i),
  .comp_pol_i(comp_pol_i), .run_hold_i(run_hold_i), .idle_hold_i(idle_hold_i),
  .main_o(main_o), .main_oe_o(main_oe_o), .comp_o(comp_o), .comp_oe_o(comp_oe_o)
);

// File: tb/cpl_deadtime_bench.sv
`timescale 1ns/1ps
module cpl_deadtime_bench;
  logic clk = 1'b0, rst_n = 1'b0, ref_i = 1'b0, tick_i = 1'b1;
  logic [7:0] dt_code = 8'd4;
  logic main_en = 1, comp_en = 1, main_pol = 0, comp_pol = 0;
  logic gate_en = 1, trip = 0, run_hold = 0, idle_hold = 0, main_idle = 0, comp_idle = 0;
  logic main_o, main_oe_o, comp_o, comp_oe_o;

  int n_tests = 0, n_fail = 0;
  bit chk_on = 0, done = 0;
  string req = "R11";

  cpl_deadtime u_cpl_deadtime (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .tick_i(tick_i), .dt_code_i(dt_code),
    .main_en_i(main_en), .comp_en_i(comp_en), .main_pol_i(main_pol), .comp_pol_i(comp_pol),
    .gate_en_i(gate_en), .trip_i(trip), .run_hold_i(run_hold), .idle_hold_i(idle_hold),
    .main_idle_i(main_idle), .comp_idle_i(comp_idle),
    .main_o(main_o), .main_oe_o(main_oe_o), .comp_o(comp_o), .comp_oe_o(comp_oe_o));

  always #2 clk = ~clk;

  int tick_div = 1, tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    tick_i <= (tick_ph == 0);
  end

  function automatic int dt_len(logic [7:0] c);
    if (!c[7]) return int'(c);
    else if (!c[6]) return 2 * (64 + int'(c[5:0]));
    else if (!c[5]) return 8 * (32 + int'(c[4:0]));
    else return 16 * (32 + int'(c[4:0]));
  endfunction

  // behavioural reference: time since last reference change, in ticks
  bit m_ref, m_set;
  int m_since;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 0; m_set = 0; m_since = 1 << 20;
    end else begin
      if (ref_i !== m_ref) begin m_ref = ref_i; m_since = 0; end
      else if (tick_i && m_since < (1 << 20)) m_since++;
      if (m_since >= dt_len(dt_code)) m_set = m_ref;
    end
  end

  task automatic expect_pins(output bit em, output bit eme, output bit ec, output bit ece);
    bit live, ma, ca;
    live = gate_en && !trip;
    ma = 0; ca = 0;
    if (main_en && comp_en) begin ma = m_ref && m_set; ca = !m_ref && !m_set; end
    else if (main_en) ma = m_ref;
    else if (comp_en) ca = m_ref;
    if (live) begin
      em = ma ^ main_pol; ec = ca ^ comp_pol;
      eme = main_en || (run_hold && (main_en || comp_en));
      ece = comp_en || (run_hold && (main_en || comp_en));
    end else begin
      em = main_idle; ec = comp_idle;
      eme = idle_hold && (main_en || comp_en);
      ece = eme;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (chk_on && rst_n) begin
      bit em, eme, ec, ece;
      expect_pins(em, eme, ec, ece);
      n_tests++;
      if ({main_o, main_oe_o, comp_o, comp_oe_o} !== {em, eme, ec, ece}) begin
        n_fail++;
        $display("FAIL %s: main/oe comp/oe = %b%b %b%b expected %b%b %b%b", req,
                 main_o, main_oe_o, comp_o, comp_oe_o, em, eme, ec, ece);
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pwm(int hi, int lo, int reps);
    for (int i = 0; i < reps; i++) begin
      ref_i = 1; cyc(hi);
      ref_i = 0; cyc(lo);
    end
  endtask

  // R1 / R3: turn-on delays for a given code, tick every cycle
  task automatic measure(logic [7:0] code, int n);
    int c;
    cyc(1); dt_code = code; cyc(3);
    ref_i = 1; c = 0;
    do begin @(posedge clk); #1; c++; end while (!main_o && c < 3000);
    check("R1 main turn-on delay", c, n + 1);
    @(negedge clk); cyc(2);
    ref_i = 0; c = 0;
    do begin @(posedge clk); #1; c++; end while (!comp_o && c < 3000);
    check("R3 comp turn-on delay", c, n + 1);
    @(negedge clk); cyc(3);
  endtask

  initial begin
    bit seen;
    cyc(3);
    check("R11 reset main_o", main_o, 0);
    check("R11 reset comp_o", comp_o, 1);
    check("R11 reset oe", {main_oe_o, comp_oe_o}, 3);
    rst_n = 1; chk_on = 1;
    cyc(2);
    check("R11 comp active after reset", comp_o, 1);

    req = "R2"; pwm(20, 15, 4);
    req = "R3"; pwm(7, 25, 3);

    req = "R1";
    cyc(10);
    measure(8'h05, 5);
    measure(8'h00, 0);
    measure(8'h7F, 127);
    measure(8'h82, 132);
    measure(8'hC1, 264);
    measure(8'hE0, 512);

    req = "R4"; dt_code = 8'd10; cyc(20);
    ref_i = 1; cyc(6); ref_i = 0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (main_o) seen = 1; end
    check("R4 short high pulse swallowed", seen, 0);
    @(negedge clk); cyc(20);
    ref_i = 0; cyc(2); ref_i = 1; cyc(1);
    seen = 0;
    ref_i = 1;
    // short low pulse: comp must not turn on
    cyc(15); ref_i = 0; cyc(5); ref_i = 1;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (comp_o) seen = 1; end
    check("R4 short low pulse swallowed", seen, 0);
    @(negedge clk); ref_i = 0; cyc(20);

    req = "R12"; dt_code = 8'd4; tick_div = 3; cyc(20);
    pwm(30, 30, 3); pwm(11, 13, 3);
    tick_div = 1; cyc(20);

    req = "R5"; main_pol = 1; comp_pol = 1; pwm(12, 12, 2);
    main_pol = 1; comp_pol = 0; pwm(10, 14, 2);
    main_pol = 0; comp_pol = 0; cyc(10);

    req = "R6"; comp_en = 0; run_hold = 0; pwm(6, 9, 3);
    req = "R8"; run_hold = 1; pwm(6, 9, 2);
    req = "R7"; main_en = 0; comp_en = 1; run_hold = 0; pwm(5, 8, 2);
    comp_pol = 1; pwm(5, 8, 2); comp_pol = 0;
    req = "R8"; run_hold = 1; pwm(5, 8, 2);
    main_en = 0; comp_en = 0; pwm(5, 5, 1);
    run_hold = 0; main_en = 1; comp_en = 1; ref_i = 0; cyc(20);

    req = "R9"; gate_en = 0;
    for (int h = 0; h < 2; h++)
      for (int lv = 0; lv < 4; lv++)
        for (int en = 0; en < 4; en++) begin
          idle_hold = h[0]; {main_idle, comp_idle} = lv[1:0]; {main_en, comp_en} = en[1:0];
          pwm(2, 3, 1);
        end
    gate_en = 1; idle_hold = 0; main_idle = 0; comp_idle = 1; main_en = 1; comp_en = 1;
    cyc(20);

    req = "R10";
    for (int i = 0; i < 3; i++) begin
      ref_i = 1; cyc(8); trip = 1; cyc(3); idle_hold = 1; cyc(3);
      trip = 0; idle_hold = 0; cyc(4); ref_i = 0; cyc(9);
    end

    cyc(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule